// File: doc/BRIEF.md
# Split High/Low Pulse-Width Meter

This block watches one asynchronous digital input and measures, in system clocks, how long each high phase lasts and how long each low phase lasts. The two polarities are kept fully apart: a high phase only ever updates the high result, and a low phase only ever updates the low result. This suits inputs whose duty cycle is not 50 % and where the two half-periods are compared separately.

The input is brought into the clock domain by two flops. Each new sample is compared with the one before it to find rising and falling edges. One saturating counter runs while the synchronised level is high and another runs while it is low. When the level flips, the counter of the phase that just ended is examined. A zero count is ignored, as is a count at or below a fixed glitch limit (200 clocks by default). Any larger count is accepted into an eight-deep running average for its polarity. The averaged widths are reported with a valid flag per polarity. A programmable timeout raises a flag and withdraws both valid flags when no accepted phase arrives for too long.

The results are status-style outputs with no back-pressure. A result is overwritten when the next accepted phase of the same polarity arrives, and a consumer may sample it at any time.

Top module: `pulse_width_meter`

## Requirements
- R1: Edges are detected from the two-flop synchronised input by comparing the current and previous samples: 00 and 11 are stable, 01 is a rising edge and 10 is a falling edge. An accepted input change shows on the width output in the third clock after the input changes.
- R2: A high phase held for N clocks at the input yields a high sample of exactly N, and a low phase held for N clocks yields a low sample of exactly N.
- R3: A phase's count is taken only when the synchronised level moves to the opposite value. The counter for that phase is then cleared to zero in the same clock.
- R4: A phase that completes with a count of zero is ignored. This includes the phase that was in progress before the first edge after reset, which is never counted.
- R5: A completed phase of GLITCH_MAX (200) clocks or fewer is discarded and leaves both outputs unchanged. A phase of 201 clocks is accepted.
- R6: Each width output equals floor(sum / 8) of the last eight accepted samples of that polarity. Unfilled slots count as zero.
- R7: A valid flag is 0 until eight samples of its polarity have been accepted since reset.
- R8: Samples of one polarity never alter the width or valid flag of the other polarity.
- R9: Each phase counter is CNT_W bits wide (20 by default, which covers phases up to 200000 clocks). It saturates at 2^CNT_W-1 instead of wrapping.
- R10: When timeout_limit is non-zero and no phase has been accepted for timeout_limit clocks, timeout goes to 1 and both valid flags go to 0. The next accepted phase clears timeout and restores the valid flag of its own polarity only. A timeout_limit of 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous input being measured |
| timeout_limit | input | TMO_W | Clocks without an accepted phase before timeout; 0 disables |
| high_width | output | CNT_W | Average of the last eight accepted high phases |
| high_valid | output | 1 | High average is filled and fresh |
| low_width | output | CNT_W | Average of the last eight accepted low phases |
| low_valid | output | 1 | Low average is filled and fresh |
| timeout | output | 1 | No accepted phase within timeout_limit clocks |

## Verification
The bench targets the glitch boundary with phases of exactly 200 and 201 clocks. A design with an off-by-one compare would either report a runt or lose a real phase. It checks that the unmeasured phase before the first edge is dropped; a design that armed counting at reset would push a partial width into the low average. A narrow instance drives a phase longer than its counter range to confirm that the counter clamps; a wrapping counter would report a small value. The bench also runs the timeout with both the valid flags withdrawn and the per-polarity recovery, and it probes the exact cycle an output moves so that a missing or extra pipeline stage shows up.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10
  } edge_e;
endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync
  import pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig_in,
  output logic  level,
  output edge_e edge_kind
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= sig_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;

  // {previous, current}: 01 rising, 10 falling, otherwise stable
  always_comb begin
    unique case ({prev_q, sync_q})
      2'b01:   edge_kind = EDGE_RISE;
      2'b10:   edge_kind = EDGE_FALL;
      default: edge_kind = EDGE_NONE;
    endcase
  end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
  import pwm_pkg::*;
#(
  parameter int   CNT_W      = 20,
  parameter int   GLITCH_MAX = 200,
  parameter logic POL        = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  edge_e            edge_kind,
  input  logic             armed,
  output logic [CNT_W-1:0] sample,
  output logic             push
);
  localparam logic [CNT_W-1:0] SAT_VAL   = '1;
  localparam logic [CNT_W-1:0] RUNT_LIM  = CNT_W'(GLITCH_MAX);
  localparam edge_e            LEAVE_EDG = POL ? EDGE_FALL : EDGE_RISE;

  logic [CNT_W-1:0] acc_q;
  logic             count_en, leave;

  assign leave    = (edge_kind == LEAVE_EDG);
  assign count_en = (level == POL) && (armed || edge_kind != EDGE_NONE);
  assign sample   = acc_q;
  assign push     = leave && (acc_q > RUNT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          acc_q <= '0;
    else if (leave)                      acc_q <= '0;
    else if (count_en && acc_q != SAT_VAL) acc_q <= acc_q + 1'b1;
  end

  assert_clear_after_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (acc_q == '0));
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == SAT_VAL && level == POL) |=> (acc_q == SAT_VAL || $past(leave)));
endmodule

// File: rtl/pwm_avg8.sv
module pwm_avg8 #(
  parameter int W        = 20,
  parameter int AVG_LOG2 = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] avg,
  output logic         full
);
  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SUM_W = W + AVG_LOG2;

  logic [W-1:0]        ring_q [DEPTH];
  logic [AVG_LOG2-1:0] ptr_q;
  logic [AVG_LOG2:0]   fill_q;
  logic [SUM_W-1:0]    sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (push) begin
      ring_q[ptr_q] <= din;
      ptr_q         <= ptr_q + 1'b1;
      sum_q         <= sum_q + SUM_W'(din) - SUM_W'(ring_q[ptr_q]);
      if (fill_q != (AVG_LOG2+1)'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  assign avg  = W'(sum_q >> AVG_LOG2);
  assign full = (fill_q == (AVG_LOG2+1)'(DEPTH));

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= (AVG_LOG2+1)'(DEPTH));
  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int GLITCH_MAX = 200,
  parameter int AVG_LOG2   = 3,
  parameter int TMO_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [TMO_W-1:0] timeout_limit,
  output logic [CNT_W-1:0] high_width,
  output logic             high_valid,
  output logic [CNT_W-1:0] low_width,
  output logic             low_valid,
  output logic             timeout
);
  localparam logic [TMO_W-1:0] TMO_SAT = '1;

  logic             level, armed_q;
  edge_e            edge_kind;
  logic [1:0]       push, full, fresh_q;
  logic [CNT_W-1:0] sample [2];
  logic [CNT_W-1:0] avg    [2];
  logic [TMO_W-1:0] tmo_cnt_q;
  logic             tmo_q, tmo_hit, any_push;

  pwm_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .level(level), .edge_kind(edge_kind)
  );

  // counting starts only once an edge has been seen (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (edge_kind != EDGE_NONE) armed_q <= 1'b1;
  end

  // index 0 measures low phases, index 1 high phases
  for (genvar p = 0; p < 2; p++) begin : g_pol
    pwm_phase_acc #(.CNT_W(CNT_W), .GLITCH_MAX(GLITCH_MAX), .POL(p[0])) u_acc (
      .clk(clk), .rst_n(rst_n), .level(level), .edge_kind(edge_kind),
      .armed(armed_q), .sample(sample[p]), .push(push[p])
    );
    pwm_avg8 #(.W(CNT_W), .AVG_LOG2(AVG_LOG2)) u_avg (
      .clk(clk), .rst_n(rst_n), .push(push[p]), .din(sample[p]),
      .avg(avg[p]), .full(full[p])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fresh_q[p] <= 1'b0;
      else if (push[p]) fresh_q[p] <= 1'b1;
      else if (tmo_hit) fresh_q[p] <= 1'b0;
    end
  end

  assign any_push = |push;
  assign tmo_hit  = (timeout_limit != '0) && (tmo_cnt_q >= timeout_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt_q <= '0;
      tmo_q     <= 1'b0;
    end else begin
      if (any_push)                  tmo_cnt_q <= '0;
      else if (tmo_cnt_q != TMO_SAT) tmo_cnt_q <= tmo_cnt_q + 1'b1;
      if (any_push)     tmo_q <= 1'b0;
      else if (tmo_hit) tmo_q <= 1'b1;
    end
  end

  assign high_width = avg[1];
  assign low_width  = avg[0];
  assign high_valid = full[1] & fresh_q[1];
  assign low_valid  = full[0] & fresh_q[0];
  assign timeout    = tmo_q;

  assert_timeout_kills_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!high_valid && !low_valid));
  assert_push_clears_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_push |=> !timeout);
endmodule

// File: tb/pulse_width_meter_bench.sv
module pulse_width_meter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic        sig_sat = 1'b0;
  logic [23:0] limit = 24'd100000;
  logic [19:0] hw, lw;
  logic        hv, lv, tmo;
  logic [9:0]  s_hw, s_lw;
  logic        s_hv, s_lv, s_tmo;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  int hist [2][8];
  int wp [2];
  int cnt [2];
  bit fresh [2];
  bit armed_m = 0;
  logic cur_lvl = 1'b0;
  int cur_len = 0;

  always #2.5 clk = ~clk;

  pulse_width_meter u_pulse_width_meter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .timeout_limit(limit),
    .high_width(hw), .high_valid(hv), .low_width(lw), .low_valid(lv), .timeout(tmo)
  );

  pulse_width_meter #(.CNT_W(10)) u_pulse_width_meter_sat (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_sat), .timeout_limit(24'd0),
    .high_width(s_hw), .high_valid(s_hv), .low_width(s_lw), .low_valid(s_lv), .timeout(s_tmo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_avg(input int p);
    int s = 0;
    for (int i = 0; i < 8; i++) s += hist[p][i];
    return s >>> 3;
  endfunction

  function automatic int exp_valid(input int p);
    return (cnt[p] >= 8 && fresh[p]) ? 1 : 0;
  endfunction

  // a new level begins: close the model's current phase
  task automatic begin_phase(input logic lvl);
    if (lvl != cur_lvl) begin
      if (armed_m && cur_len > 200) begin
        int p = cur_lvl ? 1 : 0;
        hist[p][wp[p]] = cur_len;
        wp[p] = (wp[p] + 1) % 8;
        cnt[p]++;
        fresh[p] = 1;
      end
      armed_m = 1;
      cur_len = 0;
      cur_lvl = lvl;
    end
    @(negedge clk);
    sig_in = lvl;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " high_width"}, int'(hw), exp_avg(1));
    chk({tag, " low_width"}, int'(lw), exp_avg(0));
    chk({tag, " high_valid"}, int'(hv), exp_valid(1));
    chk({tag, " low_valid"}, int'(lv), exp_valid(0));
  endtask

  task automatic run_phase(input logic lvl, input int n, input string tag);
    begin_phase(lvl);
    cur_len += n;
    repeat (n - 1) @(negedge clk);
    if (n >= 10) check_all(tag);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      wp[p] = 0; cnt[p] = 0; fresh[p] = 0;
      for (int i = 0; i < 8; i++) hist[p][i] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk("R7 reset high_valid", int'(hv), 0);
    chk("R7 reset low_valid", int'(lv), 0);
    chk("R6 reset high_width", int'(hw), 0);
    chk("R10 reset timeout", int'(tmo), 0);
    rst_n = 1'b1;

    // R9: narrow instance, 1500-clock high phase clamps at 1023
    repeat (50) @(negedge clk);
    sig_sat = 1'b1;
    repeat (1500) @(negedge clk);
    sig_sat = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 saturated high avg", int'(s_hw), 1023 >> 3);
    chk("R8 sat low untouched", int'(s_lw), 0);

    // R4: the low phase before the first edge is never counted
    cur_len = 1600;
    run_phase(1'b1, 400, "R4 first phase ignored");
    // R1: exact output cycle after the falling change
    begin_phase(1'b0);
    @(negedge clk); @(negedge clk);
    chk("R1 two clocks after change", int'(hw), 0);
    @(negedge clk);
    chk("R1 three clocks after change R2", int'(hw), 400 >> 3);
    cur_len += 300;
    repeat (296) @(negedge clk);
    check_all("R2 low after first fall");

    // R5 boundary: 200 discarded, 201 accepted
    run_phase(1'b1, 500, "R5 pre");
    run_phase(1'b0, 200, "R5 low 200 discarded");
    run_phase(1'b1, 350, "R5 after 200 glitch");
    run_phase(1'b0, 201, "R5 low 201 accepted");
    run_phase(1'b1, 200, "R5 high 200 discarded");
    run_phase(1'b0, 600, "R5 after high glitch");
    run_phase(1'b1, 201, "R5 high 201 accepted");

    // constrained random mix: R2 R6 R7 R8
    for (int k = 0; k < 70; k++) begin
      int r = $urandom_range(0, 99);
      int n = (r < 15) ? $urandom_range(1, 200) : $urandom_range(201, 2500);
      run_phase(~cur_lvl, n, "R6 random");
    end
    run_phase(~cur_lvl, 700, "R7 filled");
    chk("R7 both valid after fill", int'(hv & lv), 1);

    // R10 timeout
    begin_phase(~cur_lvl);
    cur_len += 2500;
    repeat (5) @(negedge clk);
    limit = 24'd2000;
    repeat (2494) @(negedge clk);
    chk("R10 timeout set", int'(tmo), 1);
    chk("R10 high_valid dropped", int'(hv), 0);
    chk("R10 low_valid dropped", int'(lv), 0);
    fresh[0] = 0; fresh[1] = 0;
    run_phase(~cur_lvl, 400, "R10 recovery one polarity");
    chk("R10 timeout cleared", int'(tmo), 0);
    limit = 24'd0;
    run_phase(~cur_lvl, 5000, "R10 disabled");
    chk("R10 limit zero no timeout", int'(tmo), 0);
    run_phase(~cur_lvl, 900, "R10 other polarity back");
    run_phase(~cur_lvl, 900, "R8 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule